// File: doc/BRIEF.md
# Fractional Nanosecond Baud Generator

This block produces the oversampling strobe for a UART's receive and transmit paths. It does not count reference-clock cycles. It takes the sampling period as a time in nanoseconds. That period has an integer part and a fraction counted in 255ths of a nanosecond. The reference clock period is a build parameter, given in the same 1/255-ns unit. Every clock, a phase accumulator adds that period. When the accumulated time reaches the programmed period, the block emits a sample tick and keeps the remainder for the next period. Over a long run the average tick spacing therefore matches the programmed period, even when it is not a whole number of clocks.

Software sets the oversampling ratio by writing one of two fixed configuration codes: one selects 8 samples per bit and the other selects 16. The usual choice is 8x for 4 Mbit/s and faster, and 16x below that. The programmed period is 1e9 / (baud x samples) ns. The integer part of the quotient goes in the upper field. The remainder, scaled by 255, goes in the lower field. A second output marks each completed bit, which is every 8th or 16th sample tick.

Top module: `frac_baud_gen`

## Requirements
- R1: The divisor word holds the sampling period in 1/255-ns units as T = div[31:8]*255 + div[7:0]. Bits 31:8 are whole nanoseconds and bits 7:0 are 255ths of a nanosecond.
- R2: Let the period be T and the reference period be P, with T > P. Let n be the number of clock edges since the last restart. After edge n, sample_tick_o is high exactly when floor(n*P/T) > floor((n-1)*P/T).
- R3: bit_tick_o is high only together with sample_tick_o. It rises on the k-th sample tick since the last restart whenever k is a multiple of the ratio, which is 8 or 16.
- R4: A write of CODE_8X (default 32'h0000_0A08) to the configuration port selects 8x. A write of CODE_16X (default 32'h0000_0A10) selects 16x. Any other value is ignored: the ratio stays the same and there is no restart.
- R5: A divisor write or an accepted mode write restarts the generator. In the next cycle both ticks are low, and the phase and the sample count start again from zero.
- R6: While div[31:8] is zero, neither tick is ever asserted.
- R7: If T <= P and div[31:8] is nonzero, sample_tick_o is high on every clock after the edge that follows a restart.
- R8: After reset both ticks are low, the divisor is zero (so the generator is disabled), and the ratio is 16x.
- R9: Over a long run, the average spacing between sample ticks differs from T/P clocks by at most one reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_we_i | input | 1 | Divisor write strobe |
| div_i | input | 32 | Divisor word: integer ns in 31:8, fraction in 7:0 |
| cfg_we_i | input | 1 | Mode configuration write strobe |
| cfg_i | input | 32 | Mode configuration code |
| sample_tick_o | output | 1 | One-clock oversampling strobe |
| bit_tick_o | output | 1 | One-clock strobe at each completed bit |

## Verification
The hardest condition to reach is a write that lands in the middle of a period, while the accumulator holds a nonzero remainder and the bit counter is part-way through a bit. The bench reaches it by running long enough that both are mid-flight, then rewriting the same divisor. The correct response is a restart with a fresh phase; an unchanged divisor must not be taken as a no-op. The bench also sends an invalid mode code at such a point, where nothing may change. A reference model built on the closed-form count floor(n*P/T) is compared with the outputs on every clock. The bench also drives periods just above and below one reference clock, where the accumulator's clamp and carry paths meet.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int unsigned FRAC_DEN = 255;

  typedef enum logic {
    OSR_16 = 1'b0,
    OSR_8  = 1'b1
  } osr_e;
endpackage

// File: rtl/frac_baud_cfg.sv
module frac_baud_cfg
  import frac_baud_pkg::*;
#(
  parameter int unsigned DIV_W    = 32,
  parameter int unsigned CFG_W    = 32,
  parameter logic [CFG_W-1:0] CODE_8X  = 32'h0000_0A08,
  parameter logic [CFG_W-1:0] CODE_16X = 32'h0000_0A10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [DIV_W-1:0] div_o,
  output osr_e             osr_o,
  output logic             restart_o
);
  logic is_8x, is_16x, cfg_ok;
  logic [DIV_W-1:0] div_q;
  osr_e osr_q;

  assign is_8x  = (cfg_i == CODE_8X);
  assign is_16x = (cfg_i == CODE_16X);
  assign cfg_ok = cfg_we_i && (is_8x || is_16x);
  assign restart_o = div_we_i || cfg_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      osr_q <= OSR_16;
    end else begin
      if (div_we_i) div_q <= div_i;
      if (cfg_ok)   osr_q <= is_8x ? OSR_8 : OSR_16;
    end
  end

  assign div_o = div_q;
  assign osr_o = osr_q;

  // R4
  cfg_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !is_8x && !is_16x && !div_we_i) |=> $stable(osr_q) && $stable(div_q));
endmodule

// File: rtl/frac_baud_acc.sv
module frac_baud_acc #(
  parameter int unsigned ACC_W        = 34,
  parameter int unsigned REF_PERIOD_U = 2040
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] thresh_i,
  output logic             hit_o,
  output logic             tick_o
);
  localparam logic [ACC_W-1:0] RefU  = ACC_W'(REF_PERIOD_U);
  localparam logic [ACC_W-1:0] RefU2 = ACC_W'(2 * REF_PERIOD_U);

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic fast, hit, tick_q;

  assign sum  = acc_q + RefU;
  assign fast = (thresh_i <= RefU);
  assign hit  = en_i && (fast || (sum >= thresh_i));

  always_comb begin
    if (restart_i || !en_i || fast) acc_d = '0;
    else if (hit)                   acc_d = sum - thresh_i;
    else                            acc_d = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= restart_i ? 1'b0 : hit;
    end
  end

  assign hit_o  = hit && !restart_i;
  assign tick_o = tick_q;

  // R2
  acc_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fast) |-> (acc_q < thresh_i));
  // R2
  no_double_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && (thresh_i > RefU2)) |=> !tick_q);
  // R5
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!tick_q && acc_q == '0));
endmodule

// File: rtl/frac_baud_bitdiv.sv
module frac_baud_bitdiv
  import frac_baud_pkg::*;
#(
  parameter int unsigned OSR_LO = 8,
  parameter int unsigned OSR_HI = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  osr_e osr_i,
  input  logic samp_i,
  output logic bit_tick_o
);
  localparam int unsigned CNT_W = $clog2(OSR_HI);
  localparam logic [CNT_W-1:0] LastLo = CNT_W'(OSR_LO - 1);
  localparam logic [CNT_W-1:0] LastHi = CNT_W'(OSR_HI - 1);

  logic [CNT_W-1:0] cnt_q, last;
  logic bit_q, wrap;

  assign last = (osr_i == OSR_8) ? LastLo : LastHi;
  assign wrap = samp_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else begin
      bit_q <= wrap;
      if (wrap)        cnt_q <= '0;
      else if (samp_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_tick_o = bit_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
  // R5
  bit_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !bit_q);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int unsigned DIV_W        = 32,
  parameter int unsigned FRAC_W       = 8,
  parameter int unsigned CFG_W        = 32,
  parameter int unsigned REF_PERIOD_U = 2040,
  parameter int unsigned OSR_LO       = 8,
  parameter int unsigned OSR_HI       = 16,
  parameter logic [CFG_W-1:0] CODE_8X  = 32'h0000_0A08,
  parameter logic [CFG_W-1:0] CODE_16X = 32'h0000_0A10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             sample_tick_o,
  output logic             bit_tick_o
);
  localparam int unsigned INT_W = DIV_W - FRAC_W;
  localparam int unsigned ACC_W = DIV_W + 2;

  logic [DIV_W-1:0] div_q;
  logic [INT_W-1:0] int_part;
  logic [FRAC_W-1:0] frac_part;
  logic [ACC_W-1:0] thresh;
  logic restart, en, hit;
  osr_e osr;

  frac_baud_cfg #(
    .DIV_W(DIV_W), .CFG_W(CFG_W), .CODE_8X(CODE_8X), .CODE_16X(CODE_16X)
  ) u_cfg (
    .clk_i, .rst_ni, .div_we_i, .div_i, .cfg_we_i, .cfg_i,
    .div_o(div_q), .osr_o(osr), .restart_o(restart)
  );

  assign int_part  = div_q[DIV_W-1:FRAC_W];
  assign frac_part = div_q[FRAC_W-1:0];
  assign en        = (int_part != '0);
  assign thresh    = ACC_W'(int_part) * ACC_W'(FRAC_DEN) + ACC_W'(frac_part);

  frac_baud_acc #(.ACC_W(ACC_W), .REF_PERIOD_U(REF_PERIOD_U)) u_acc (
    .clk_i, .rst_ni, .restart_i(restart), .en_i(en), .thresh_i(thresh),
    .hit_o(hit), .tick_o(sample_tick_o)
  );

  frac_baud_bitdiv #(.OSR_LO(OSR_LO), .OSR_HI(OSR_HI)) u_bit (
    .clk_i, .rst_ni, .restart_i(restart), .osr_i(osr), .samp_i(hit),
    .bit_tick_o
  );

  // R3
  bit_with_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (!sample_tick_o && !bit_tick_o));
  // R7
  fast_every_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && thresh <= ACC_W'(REF_PERIOD_U) && !restart) |=> sample_tick_o);
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  localparam int CLK_PERIOD = 8;
  localparam longint REF = 2040;
  localparam logic [31:0] C8  = 32'h0000_0A08;
  localparam logic [31:0] C16 = 32'h0000_0A10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic div_we = 1'b0, cfg_we = 1'b0;
  logic [31:0] div = '0, cfg = '0;
  logic s_tick, b_tick;

  int total = 0, bad = 0;
  string tag = "R8";

  logic [31:0] m_div = '0;
  int m_osr = 16;
  longint m_n = 0, m_sc = 0, cycles = 0;
  logic e_s = 1'b0, e_b = 1'b0;
  bit trk = 0;
  longint tk_first = 0, tk_last = 0, tk_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_baud_gen #(.REF_PERIOD_U(2040)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .div_we_i(div_we), .div_i(div),
    .cfg_we_i(cfg_we), .cfg_i(cfg), .sample_tick_o(s_tick), .bit_tick_o(b_tick)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cycles, act, exp);
    end
  endtask

  function automatic [31:0] mk(input int ip, input int fp);
    return {ip[23:0], fp[7:0]};
  endfunction

  task automatic cyc(input logic dwe, input logic [31:0] d, input logic cwe, input logic [31:0] c);
    bit valid;
    longint t;
    div_we = dwe; div = d; cfg_we = cwe; cfg = c;
    @(posedge clk);
    valid = cwe && (c == C8 || c == C16);
    if (dwe) m_div = d;
    if (valid) m_osr = (c == C8) ? 8 : 16;
    if (dwe || valid) begin
      m_n = 0; m_sc = 0; e_s = 0; e_b = 0;
    end else begin
      t = longint'(m_div[31:8]) * 255 + longint'(m_div[7:0]);
      if (m_div[31:8] == 0) e_s = 0;
      else if (t <= REF) e_s = 1;
      else begin
        m_n++;
        e_s = ((m_n * REF) / t) != (((m_n - 1) * REF) / t);
      end
      if (e_s) m_sc++;
      e_b = e_s && (m_sc % m_osr == 0);
    end
    cycles++;
    if (e_s && trk) begin
      if (tk_cnt == 0) tk_first = cycles;
      tk_last = cycles;
      tk_cnt++;
    end
    @(negedge clk);
    chk(tag, s_tick, e_s, "sample_tick");
    chk(tag, b_tick, e_b, "bit_tick");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, '0);
  endtask

  task automatic avg_chk(input string req);
    real ideal, avg;
    ideal = (real'(longint'(m_div[31:8]) * 255 + longint'(m_div[7:0]))) / real'(REF);
    total++;
    if (tk_cnt < 2) begin
      bad++;
      $display("FAIL %s too few ticks: actual=%0d expected>=2", req, tk_cnt);
    end else begin
      avg = real'(tk_last - tk_first) / real'(tk_cnt - 1);
      if (avg - ideal > 1.0 || ideal - avg > 1.0) begin
        bad++;
        $display("FAIL %s avg spacing: actual=%f expected=%f", req, avg, ideal);
      end
    end
    trk = 0; tk_cnt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8", s_tick, 1'b0, "sample_tick in reset");
      chk("R8", b_tick, 1'b0, "bit_tick in reset");
    end
    rst_ni = 1'b1;
    tag = "R6 R8"; run(40);
    tag = "R6"; cyc(1'b1, mk(0, 200), 1'b0, '0); run(50);

    // R1 R2 R3 R8: 115200 baud, 16x from reset default
    tag = "R1 R2 R3 R8";
    cyc(1'b1, mk(542, 136), 1'b0, '0);
    trk = 1; run(16000); avg_chk("R9");

    // R4 R3: 4 Mbit/s, 8x
    tag = "R4 R3 R2";
    cyc(1'b1, mk(31, 63), 1'b1, C8);
    trk = 1; run(3000); avg_chk("R9");

    // R4: invalid code mid-run, no restart, mode kept
    tag = "R4";
    cyc(1'b0, '0, 1'b1, 32'h0000_1234); run(500);
    cyc(1'b0, '0, 1'b1, C8 ^ 32'h1); run(200);

    // R5: rewrite identical divisor mid-phase
    tag = "R5"; run(17);
    cyc(1'b1, mk(31, 63), 1'b0, '0); run(300);
    // R5: accepted mode write alone restarts
    tag = "R5 R4"; run(9);
    cyc(1'b0, '0, 1'b1, C16); run(1000);

    // R7: period at or below one clock
    tag = "R7"; cyc(1'b1, mk(5, 0), 1'b0, '0); run(40);
    tag = "R7"; cyc(1'b1, mk(8, 0), 1'b0, '0); run(40);
    // R2: just above one clock
    tag = "R2"; cyc(1'b1, mk(8, 1), 1'b1, C8); run(400);

    // R6: disable again mid-run
    tag = "R6"; cyc(1'b1, mk(0, 17), 1'b0, '0); run(60);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule